// File: doc/BRIEF.md
# Upset-Correcting Sequencer With Coded State

This block is a small Moore sequencer whose state register is stored as a single-error-correcting, double-error-detecting codeword. Each clock edge writes the encoded next state and its check bits together. Before the stored word is used, a decode stage repairs it. The repaired present state drives both the transition logic and the decoded outputs. A single flipped flip-flop therefore never changes what the sequencer does.

The sequencer has six states: idle, arm, three run phases and done. A start input leaves idle. The step input advances the run phases, and abort returns the run phases to idle. Two flags report the health of the stored word. One pulses when a single bit was repaired. The other rises when two bits disagree with the code; in that case the outputs show idle and the next edge returns the sequencer to idle. Fault-injection ports let a test flip chosen stored bits at a chosen edge.

Top module: `pfsm_seu_guard`

## Requirements
- R1: Reset is synchronous and active high. After an edge with `rst` high, `state_o` is 0 (idle), `busy`, `done`, `corrected` and `uncorrectable` are all 0.
- R2: State codes are idle=0, arm=1, run0=2, run1=3, run2=4, done=5. Idle moves to arm when `start` is high and otherwise stays. Arm always moves to run0. Done always moves to idle.
- R3: In run0, run1 and run2, `abort` high moves to idle and has priority over `step`. Otherwise `step` high advances run0→run1→run2→done, and with neither input high the state holds.
- R4: `state_o` shows the corrected present state. `busy` is 1 exactly for codes 1 to 4, and `done` is 1 exactly for code 5. Codes 6 to 15 never appear on `state_o`.
- R5: The stored word has 8 bits. Bit 0 is the overall parity. Bits 1, 2 and 4 are Hamming check bits. Bits 3, 5, 6 and 7 hold state bits 0 to 3. When a strobe in `inj_en[i]` is high at an edge, the bit selected by `inj_idx[3*i+2:3*i]` in the word captured at that edge is inverted. Reset takes priority over injection.
- R6: When exactly one stored bit is flipped, whichever of the 8 it is, `state_o`, `busy`, `done` and the next transition are the same as without the flip. `corrected` is 1 for that one cycle, and `uncorrectable` is 0.
- R7: When two distinct stored bits are flipped, `uncorrectable` is 1 and `corrected` is 0 for that cycle. `state_o` shows 0 and `busy`/`done` are 0. The next edge loads idle whatever the inputs are.
- R8: When no bit was injected at the previous edge, `corrected` and `uncorrectable` are both 0. The two flags are never high together.
- R9: If both injection ports select the same index at the same edge, the two flips cancel. No flag rises and the behaviour is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Leave idle |
| step | input | 1 | Advance a run phase |
| abort | input | 1 | Return from a run phase to idle |
| inj_en | input | NUM_INJ | Per-port fault-injection strobe |
| inj_idx | input | NUM_INJ*3 | Per-port stored-bit index, port i at bits 3*i+2:3*i |
| state_o | output | 4 | Corrected present state code |
| busy | output | 1 | Sequencer in arm or a run phase |
| done | output | 1 | Sequencer in done |
| corrected | output | 1 | A single stored bit was repaired this cycle |
| uncorrectable | output | 1 | Two stored bits disagree with the code |

## Verification
A long clean walk uses pseudo-random start, step and abort inputs. It compares every cycle with an arithmetic model, which separates the transition rules, the priority of abort over step and the decoded outputs. A single-flip sweep injects on each of the 8 stored bits, from both ports and in many states. A check there tells a repaired data bit apart from a repaired check bit or the overall parity bit, because any mis-repair changes `state_o` or the following transition. Every ordered pair of distinct bits is then flipped, which separates detection from miscorrection and confirms the forced return to idle. Equal indexes on both ports confirm that the two flips cancel.

// File: rtl/pfsm_pkg.sv
package pfsm_pkg;

   localparam int ST_W = 4;

   typedef enum logic [ST_W-1:0] {
      ST_IDLE = 4'd0,
      ST_ARM  = 4'd1,
      ST_RUN0 = 4'd2,
      ST_RUN1 = 4'd3,
      ST_RUN2 = 4'd4,
      ST_DONE = 4'd5
   } state_t;

   // Number of Hamming check bits needed for dw data bits.
   function automatic int par_bits(input int dw);
      int p;
      p = 0;
      for (int i = 0; i < 16; i++)
         if ((1 << i) < dw + i + 1) p = i + 1;
      return p;
   endfunction

   // Codeword position (1-based) of data bit k: the k-th position that is not a power of two.
   function automatic int data_pos(input int k);
      int cnt;
      int res;
      cnt = -1;
      res = 0;
      for (int pos = 1; pos < 64; pos++) begin
         if ((pos & (pos - 1)) != 0) begin
            cnt++;
            if (cnt == k && res == 0) res = pos;
         end
      end
      return res;
   endfunction

   // Positions (bit q of the result) whose index shares a bit with sel.
   function automatic logic [63:0] cover_mask(input int sel);
      logic [63:0] m;
      m = '0;
      for (int q = 1; q < 64; q++)
         if ((q & sel) != 0) m[q] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/pfsm_secded_enc.sv
module pfsm_secded_enc
   import pfsm_pkg::*;
#(
   parameter int DATA_W = 4,
   localparam int PAR_W = par_bits(DATA_W),
   localparam int N     = DATA_W + PAR_W,
   localparam int CW    = N + 1
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CW-1:0]     code_o
);

   logic [N:1] body;
   logic [N:1] ham;

   for (genvar pos = 1; pos <= N; pos++) begin : g_body
      if ((pos & (pos - 1)) == 0) begin : g_chk
         assign body[pos] = 1'b0;
      end
   end

   for (genvar k = 0; k < DATA_W; k++) begin : g_place
      assign body[data_pos(k)] = data_i[k];
   end

   for (genvar pos = 1; pos <= N; pos++) begin : g_ham
      if ((pos & (pos - 1)) == 0) begin : g_chk
         localparam logic [63:0] MF = cover_mask(pos);
         assign ham[pos] = ^(body & MF[N:1]);
      end else begin : g_dat
         assign ham[pos] = body[pos];
      end
   end

   assign code_o = {ham, ^ham};

endmodule

// File: rtl/pfsm_secded_dec.sv
module pfsm_secded_dec
   import pfsm_pkg::*;
#(
   parameter int DATA_W = 4,
   localparam int PAR_W = par_bits(DATA_W),
   localparam int N     = DATA_W + PAR_W,
   localparam int CW    = N + 1
) (
   input  logic [CW-1:0]     code_i,
   output logic [DATA_W-1:0] data_o,
   output logic              single_o,
   output logic              double_o
);

   logic [PAR_W-1:0] syn;
   logic             overall;
   logic             syn_bad;
   logic [CW-1:0]    fixed;

   for (genvar p = 0; p < PAR_W; p++) begin : g_syn
      localparam logic [63:0] MF = cover_mask(1 << p);
      assign syn[p] = ^(code_i[N:1] & MF[N:1]);
   end

   assign overall = ^code_i;

   // Only a code that does not fill its syndrome space can point past the word.
   if (((1 << PAR_W) - 1) > N) begin : g_range
      assign syn_bad = (int'(syn) > N);
   end else begin : g_full
      assign syn_bad = 1'b0;
   end

   always_comb begin
      fixed    = code_i;
      single_o = 1'b0;
      double_o = 1'b0;
      if (overall) begin
         if (syn_bad) begin
            double_o = 1'b1;
         end else begin
            single_o   = 1'b1;
            fixed[syn] = ~code_i[syn];
         end
      end else if (syn != '0) begin
         double_o = 1'b1;
      end
   end

   for (genvar k = 0; k < DATA_W; k++) begin : g_out
      assign data_o[k] = fixed[data_pos(k)];
   end

endmodule

// File: rtl/pfsm_ctrl.sv
module pfsm_ctrl
   import pfsm_pkg::*;
(
   input  state_t cur_i,
   input  logic   start_i,
   input  logic   step_i,
   input  logic   abort_i,
   input  logic   force_idle_i,
   output state_t nxt_o,
   output logic   busy_o,
   output logic   done_o
);

   always_comb begin
      nxt_o = ST_IDLE;
      if (!force_idle_i) begin
         unique case (cur_i)
            ST_IDLE: nxt_o = start_i ? ST_ARM : ST_IDLE;
            ST_ARM:  nxt_o = ST_RUN0;
            ST_RUN0: nxt_o = abort_i ? ST_IDLE : (step_i ? ST_RUN1 : ST_RUN0);
            ST_RUN1: nxt_o = abort_i ? ST_IDLE : (step_i ? ST_RUN2 : ST_RUN1);
            ST_RUN2: nxt_o = abort_i ? ST_IDLE : (step_i ? ST_DONE : ST_RUN2);
            ST_DONE: nxt_o = ST_IDLE;
            default: nxt_o = ST_IDLE;
         endcase
      end
   end

   always_comb begin
      busy_o = (cur_i == ST_ARM) || (cur_i == ST_RUN0) ||
               (cur_i == ST_RUN1) || (cur_i == ST_RUN2);
      done_o = (cur_i == ST_DONE);
   end

endmodule

// File: rtl/pfsm_seu_guard.sv
module pfsm_seu_guard
   import pfsm_pkg::*;
#(
   parameter  int NUM_INJ = 2,
   localparam int PAR_W   = par_bits(ST_W),
   localparam int CW      = ST_W + PAR_W + 1,
   localparam int IDX_W   = $clog2(CW)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start,
   input  logic                     step,
   input  logic                     abort,
   input  logic [NUM_INJ-1:0]       inj_en,
   input  logic [NUM_INJ*IDX_W-1:0] inj_idx,
   output logic [ST_W-1:0]          state_o,
   output logic                     busy,
   output logic                     done,
   output logic                     corrected,
   output logic                     uncorrectable
);

   if (NUM_INJ < 1 || NUM_INJ > 4) begin : g_bad_inj
      $error("pfsm_seu_guard: NUM_INJ must be 1 to 4");
   end
   if (CW != 8) begin : g_bad_cw
      $error("pfsm_seu_guard: state codeword expected to be 8 bits");
   end

   logic [CW-1:0]      stored;
   logic [CW-1:0]      enc_code;
   logic [CW-1:0]      flip;
   logic [CW-1:0]      port_mask [NUM_INJ];
   logic [ST_W-1:0]    dec_data;
   logic               dec_single;
   logic               dec_double;
   state_t             cur;
   state_t             nxt;
   state_t             load;

   pfsm_secded_dec #(.DATA_W(ST_W)) u_dec (
      .code_i   (stored),
      .data_o   (dec_data),
      .single_o (dec_single),
      .double_o (dec_double)
   );

   assign cur = dec_double ? ST_IDLE : state_t'(dec_data);

   pfsm_ctrl u_ctrl (
      .cur_i        (cur),
      .start_i      (start),
      .step_i       (step),
      .abort_i      (abort),
      .force_idle_i (dec_double),
      .nxt_o        (nxt),
      .busy_o       (busy),
      .done_o       (done)
   );

   assign load = rst ? ST_IDLE : nxt;

   pfsm_secded_enc #(.DATA_W(ST_W)) u_enc (
      .data_i (load),
      .code_o (enc_code)
   );

   for (genvar i = 0; i < NUM_INJ; i++) begin : g_inj
      assign port_mask[i] = inj_en[i] ? (CW'(1) << inj_idx[i*IDX_W +: IDX_W]) : '0;
   end

   always_comb begin
      flip = '0;
      for (int i = 0; i < NUM_INJ; i++) flip = flip ^ port_mask[i];
   end

   always_ff @(posedge clk) begin
      if (rst) stored <= enc_code;
      else     stored <= enc_code ^ flip;
   end

   assign state_o       = cur;
   assign corrected     = dec_single;
   assign uncorrectable = dec_double;

endmodule

module pfsm_seu_guard_chk #(
   parameter int NUM_INJ = 2
) (
   input logic               clk,
   input logic               rst,
   input logic [NUM_INJ-1:0] inj_en,
   input logic [3:0]         state_o,
   input logic               busy,
   input logic               done,
   input logic               corrected,
   input logic               uncorrectable
);

   AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
      state_o <= 4'd5); // R4

   AST_OUT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      $onehot0({busy, done})); // R4

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(corrected && uncorrectable)); // R8

   AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (rst)
      ($past(inj_en) == '0) |-> (!corrected && !uncorrectable)); // R8

   AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (corrected && inj_en == '0) |=> !corrected); // R6

   AST_DOUBLE_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
      (uncorrectable && inj_en == '0) |=> (state_o == 4'd0 && !uncorrectable)); // R7

endmodule

bind pfsm_seu_guard pfsm_seu_guard_chk #(.NUM_INJ(NUM_INJ)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .inj_en        (inj_en),
   .state_o       (state_o),
   .busy          (busy),
   .done          (done),
   .corrected     (corrected),
   .uncorrectable (uncorrectable)
);

// File: tb/pfsm_seu_guard_tb.sv
module pfsm_seu_guard_tb;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0, step = 1'b0, abort = 1'b0;
   logic [1:0] inj_en = 2'b00;
   logic [5:0] inj_idx = '0;
   logic [3:0] state_o;
   logic       busy, done, corrected, uncorrectable;

   int errs = 0;
   int checks = 0;
   logic [3:0]  model = 4'd0;
   logic        pend = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;

   pfsm_seu_guard #(.NUM_INJ(2)) u_dut (
      .clk(clk), .rst(rst), .start(start), .step(step), .abort(abort),
      .inj_en(inj_en), .inj_idx(inj_idx), .state_o(state_o), .busy(busy),
      .done(done), .corrected(corrected), .uncorrectable(uncorrectable)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] nxt_of(input logic [3:0] s, input logic st, sp, ab);
      case (s)
         4'd0: return st ? 4'd1 : 4'd0;
         4'd1: return 4'd2;
         4'd2, 4'd3, 4'd4: return ab ? 4'd0 : (sp ? s + 4'd1 : s);
         default: return 4'd0;
      endcase
   endfunction

   task automatic tick(input logic st, sp, ab, input logic e0, input logic [2:0] i0,
                       input logic e1, input logic [2:0] i1, input string tag);
      logic [3:0] exp;
      logic       dbl, sgl;
      exp = pend ? 4'd0 : nxt_of(model, st, sp, ab);
      dbl = e0 && e1 && (i0 != i1);
      sgl = e0 ^ e1;
      start = st; step = sp; abort = ab;
      inj_en = {e1, e0}; inj_idx = {i1, i0};
      @(posedge clk);
      @(negedge clk);
      model = exp;
      pend = dbl;
      if (dbl) begin
         chk("R7 state", 32'(state_o), 0);
         chk("R7 uncorrectable", 32'(uncorrectable), 1);
         chk("R7 corrected", 32'(corrected), 0);
         chk("R7 busy", 32'(busy), 0);
      end else begin
         chk(tag, 32'(state_o), 32'(model));
         chk("R4 busy", 32'(busy), 32'(model >= 4'd1 && model <= 4'd4));
         chk("R4 done", 32'(done), 32'(model == 4'd5));
         chk(sgl ? "R6 corrected" : "R8 corrected", 32'(corrected), 32'(sgl));
         chk("R8 uncorrectable", 32'(uncorrectable), 0);
      end
      inj_en = 2'b00;
   endtask

   task automatic rnd(output logic st, sp, ab);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ab = (lfsr[2:0] == 3'd0);
      sp = lfsr[3] | lfsr[5];
      st = lfsr[4];
   endtask

   initial begin
      #(8 * 200000);
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      logic st, sp, ab;
      // R1 and R5: reset with an injection strobe active
      @(negedge clk);
      inj_en = 2'b01; inj_idx = 6'd5; start = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 state", 32'(state_o), 0);
      chk("R1 busy", 32'(busy), 0);
      chk("R1 done", 32'(done), 0);
      chk("R5 reset beats injection", 32'(corrected), 0);
      chk("R1 uncorrectable", 32'(uncorrectable), 0);
      rst = 1'b0; inj_en = 2'b00; start = 1'b0;

      // R2/R3: directed transitions
      tick(0, 1, 1, 0, 0, 0, 0, "R2 idle holds");
      tick(1, 0, 0, 0, 0, 0, 0, "R2 idle to arm");
      tick(0, 0, 1, 0, 0, 0, 0, "R2 arm to run0");
      tick(0, 0, 0, 0, 0, 0, 0, "R3 hold");
      tick(0, 1, 1, 0, 0, 0, 0, "R3 abort priority");
      tick(1, 0, 0, 0, 0, 0, 0, "R2 arm");
      tick(0, 0, 0, 0, 0, 0, 0, "R2 run0");
      tick(0, 1, 0, 0, 0, 0, 0, "R3 run1");
      tick(0, 1, 0, 0, 0, 0, 0, "R3 run2");
      tick(0, 1, 0, 0, 0, 0, 0, "R3 done");
      tick(1, 1, 0, 0, 0, 0, 0, "R2 done to idle");

      // Clean pseudo-random walk
      for (int n = 0; n < 400; n++) begin
         rnd(st, sp, ab);
         tick(st, sp, ab, 0, 0, 0, 0, "R3 walk");
      end

      // R6: every single bit from each port, in varied states
      for (int r = 0; r < 4; r++)
         for (int b = 0; b < 8; b++)
            for (int p = 0; p < 2; p++) begin
               rnd(st, sp, ab);
               tick(st, sp, ab, p == 0, 3'(b), p == 1, 3'(b), "R5 single flip state");
               for (int c = 0; c < 3; c++) begin
                  rnd(st, sp, ab);
                  tick(st, sp, ab, 0, 0, 0, 0, "R6 after repair");
               end
            end

      // R7: every ordered pair of distinct bits
      for (int a = 0; a < 8; a++)
         for (int b = 0; b < 8; b++)
            if (a != b) begin
               tick(1, 0, 0, 0, 0, 0, 0, "R2 prepare");
               rnd(st, sp, ab);
               tick(st, sp, ab, 1, 3'(a), 1, 3'(b), "R7 pair");
               tick(1, 1, 0, 0, 0, 0, 0, "R7 forced idle");
               tick(0, 0, 0, 0, 0, 0, 0, "R7 recovered");
            end

      // R9: equal indexes cancel
      for (int b = 0; b < 8; b++) begin
         rnd(st, sp, ab);
         tick(st, sp, ab, 1, 3'(b), 1, 3'(b), "R9 cancel");
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule